// File: doc/BRIEF.md
# Exception Frame Sequencer

This block sits beside the execute stage of a 32-bit CPU and runs exception entry and return as a short sequence of bus accesses. It handles three kinds of request: a software exception with an 8-bit exception number, a hardware interrupt with a 3-bit priority level and an 8-bit vector number, and a return-from-exception. The CPU presents its current program counter, status word, condition codes, supervisor stack pointer and vector base on the input side. The block returns the new program counter, stack pointer and status word together with a one-cycle `done` strobe.

On entry the block builds a format word and rounds the stack pointer down to a longword boundary. It then pushes two longwords: the return address first, then the format word. After that it reads the handler address from the vector table. The two low bits of the stack pointer, before rounding, are kept inside the format word. On return the block reads the frame back and restores those bits, so a misaligned stack pointer comes back exactly as it was.

Memory traffic goes through a single 32-bit port with a valid/ready handshake, and only one access is open at a time. `busy` goes high in the cycle after a request is accepted. It stays high through the `done` cycle.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_valid` are all low.
- R2: Requests are sampled only while `busy` is low. Return-from-exception wins over a software exception, and a software exception wins over a hardware interrupt. `busy` is high from the cycle after acceptance through the `done` cycle.
- R3: A hardware interrupt is accepted only when `irq_level` is strictly greater than the mask field `cur_sr[10:8]`. Level 0 is therefore never taken, and a level equal to the mask is ignored.
- R4: The format word layout:
  - bit 30 is set;
  - bits 29:28 hold `cur_sp[1:0]`;
  - bits 25:16 hold the exception number times 4;
  - bits 15:0 hold `cur_sr` OR'ed with `cur_ccr` (5 bits, zero-extended);
  - all other bits are zero.
- R5: Let B be `cur_sp` with its two low bits cleared. Entry writes the return address at B-4 and then the format word at B-8. The new stack pointer is B-8, and every write address is longword aligned.
- R6: For software exception numbers 32 to 47 (the trap range), the saved return address is `cur_pc`+2. For every other number, and for hardware interrupts, it is `cur_pc`.
- R7: After both pushes, the block reads one word at `vbr` + number×4. That word becomes `new_pc`.
- R8: The new status word on entry is `cur_sr` with bit 13 (supervisor) set. For a hardware interrupt, bit 12 is also cleared and bits 10:8 are loaded with `irq_level`.
- R9: Return-from-exception reads the format word at `cur_sp` and then the PC at `cur_sp`+4. It writes nothing. It yields `new_sp` = (`cur_sp` OR format[29:28]) + 8 and `new_sr` = format[15:0]. An entry followed by a return therefore restores the original stack pointer.
- R10: At most one access is outstanding at a time. While `mem_valid` is high and `mem_ready` is low, address, write enable and write data hold steady.
- R11: `done` is high for exactly one cycle, with `new_pc`, `new_sp` and `new_sr` valid. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software exception request |
| sw_num | input | 8 | Software exception number |
| irq_level | input | 3 | Pending interrupt level, 0 means none |
| irq_vec | input | 8 | Vector number of the pending interrupt |
| rte_req | input | 1 | Return-from-exception request |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status word |
| cur_ccr | input | 5 | Current condition codes |
| cur_sp | input | 32 | Supervisor stack pointer |
| vbr | input | 32 | Vector table base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| new_pc | output | 32 | Resulting program counter |
| new_sp | output | 32 | Resulting stack pointer |
| new_sr | output | 16 | Resulting status word |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The bench drives every low-bit pattern of the stack pointer and then runs a return from the frame it just pushed. A design that drops or misplaces the saved low bits breaks that round trip. The trap boundaries 31, 32, 47 and 48 catch an off-by-one range test that would skew the return address by 2. An interrupt whose level equals the mask is offered to catch a comparison that accepts on equality, and a request with all three inputs raised catches a wrong priority order. A memory that stalls at random exposes any sequencer that moves its address or advances before `mem_ready`.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

  localparam int SR_W        = 16;
  localparam int CCR_W       = 5;
  localparam int MASK_W      = 3;
  localparam int SR_SUPER    = 13;
  localparam int SR_MASTER   = 12;
  localparam int SR_MASK_LO  = 8;
  localparam int FMT_TAG     = 30;
  localparam int FMT_SPLO    = 28;
  localparam int FMT_VEC_LO  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_FMT,
    ST_FETCH_VEC,
    ST_POP_FMT,
    ST_POP_PC,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    RQ_NONE,
    RQ_SW,
    RQ_HW,
    RQ_RTE
  } req_kind_e;

endpackage

// File: rtl/exc_accept.sv
module exc_accept
  import exc_frame_pkg::*;
#(
  parameter int NUM_W     = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_CNT  = 16
) (
  input  logic              sw_req,
  input  logic [NUM_W-1:0]  sw_num,
  input  logic [MASK_W-1:0] irq_level,
  input  logic [NUM_W-1:0]  irq_vec,
  input  logic              rte_req,
  input  logic [MASK_W-1:0] sr_mask,
  output req_kind_e         kind,
  output logic [NUM_W-1:0]  num,
  output logic              is_trap
);

  localparam int TRAP_LAST = TRAP_BASE + TRAP_CNT - 1;

  always_comb begin
    kind = RQ_NONE;
    num  = sw_num;
    if (rte_req) begin
      kind = RQ_RTE;
    end else if (sw_req) begin
      kind = RQ_SW;
    end else if (irq_level > sr_mask) begin
      kind = RQ_HW;
      num  = irq_vec;
    end
  end

  always_comb begin
    is_trap = (kind == RQ_SW) && (int'(sw_num) >= TRAP_BASE) &&
              (int'(sw_num) <= TRAP_LAST);
  end

endmodule

// File: rtl/exc_frame_build.sv
module exc_frame_build
  import exc_frame_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NUM_W = 8
) (
  input  req_kind_e         kind,
  input  logic [NUM_W-1:0]  num,
  input  logic              is_trap,
  input  logic [MASK_W-1:0] level,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [SR_W-1:0]   cur_sr,
  input  logic [CCR_W-1:0]  cur_ccr,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [XLEN-1:0]   vbr,
  output logic [XLEN-1:0]   fmt_word,
  output logic [XLEN-1:0]   ret_addr,
  output logic [SR_W-1:0]   entry_sr,
  output logic [XLEN-1:0]   sp_base,
  output logic [XLEN-1:0]   vec_addr
);

  localparam int OFF_W = NUM_W + 2;
  localparam logic [XLEN-1:0] TRAP_STEP = XLEN'(2);

  logic [OFF_W-1:0] vec_off;

  always_comb begin
    vec_off = {num, 2'b00};
    fmt_word = '0;
    fmt_word[FMT_TAG] = 1'b1;
    fmt_word[FMT_SPLO +: 2] = cur_sp[1:0];
    fmt_word[FMT_VEC_LO +: OFF_W] = vec_off;
    fmt_word[SR_W-1:0] = cur_sr | {{(SR_W-CCR_W){1'b0}}, cur_ccr};
  end

  always_comb begin
    entry_sr = cur_sr;
    entry_sr[SR_SUPER] = 1'b1;
    if (kind == RQ_HW) begin
      entry_sr[SR_MASTER] = 1'b0;
      entry_sr[SR_MASK_LO +: MASK_W] = level;
    end
  end

  always_comb begin
    ret_addr = is_trap ? (cur_pc + TRAP_STEP) : cur_pc;
    sp_base  = {cur_sp[XLEN-1:2], 2'b00};
    vec_addr = vbr + {{(XLEN-OFF_W){1'b0}}, vec_off};
  end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_W     = 8,
  parameter int TRAP_BASE = 32,
  parameter int TRAP_CNT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [NUM_W-1:0]  sw_num,
  input  logic [2:0]        irq_level,
  input  logic [NUM_W-1:0]  irq_vec,
  input  logic              rte_req,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [15:0]       cur_sr,
  input  logic [4:0]        cur_ccr,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [XLEN-1:0]   vbr,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sp,
  output logic [15:0]       new_sr,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_ready
);

  localparam logic [XLEN-1:0] WORD  = XLEN'(4);
  localparam logic [XLEN-1:0] FRAME = XLEN'(8);

  seq_state_e st_q, st_d;
  logic [XLEN-1:0] sp_q, sp_d, pc_q, pc_d, fmt_q, fmt_d, va_q, va_d;
  logic [SR_W-1:0] sr_q, sr_d;

  req_kind_e        kind;
  logic [NUM_W-1:0] num;
  logic             is_trap;
  logic [XLEN-1:0]  fmt_w, ret_w, sp_base, vec_addr;
  logic [SR_W-1:0]  entry_sr;
  logic             xfer;

  exc_accept #(
    .NUM_W(NUM_W), .TRAP_BASE(TRAP_BASE), .TRAP_CNT(TRAP_CNT)
  ) accept_i (
    .sw_req   (sw_req),
    .sw_num   (sw_num),
    .irq_level(irq_level),
    .irq_vec  (irq_vec),
    .rte_req  (rte_req),
    .sr_mask  (cur_sr[SR_MASK_LO +: MASK_W]),
    .kind     (kind),
    .num      (num),
    .is_trap  (is_trap)
  );

  exc_frame_build #(.XLEN(XLEN), .NUM_W(NUM_W)) build_i (
    .kind    (kind),
    .num     (num),
    .is_trap (is_trap),
    .level   (irq_level),
    .cur_pc  (cur_pc),
    .cur_sr  (cur_sr),
    .cur_ccr (cur_ccr),
    .cur_sp  (cur_sp),
    .vbr     (vbr),
    .fmt_word(fmt_w),
    .ret_addr(ret_w),
    .entry_sr(entry_sr),
    .sp_base (sp_base),
    .vec_addr(vec_addr)
  );

  assign xfer = mem_valid && mem_ready;

  // Memory port drive: a function of the state register only, so it holds
  // steady for as long as the access is stalled.
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      ST_PUSH_PC: begin
        mem_valid = 1'b1; mem_we = 1'b1; mem_addr = sp_q; mem_wdata = pc_q;
      end
      ST_PUSH_FMT: begin
        mem_valid = 1'b1; mem_we = 1'b1; mem_addr = sp_q; mem_wdata = fmt_q;
      end
      ST_FETCH_VEC: begin
        mem_valid = 1'b1; mem_addr = va_q;
      end
      ST_POP_FMT: begin
        mem_valid = 1'b1; mem_addr = sp_q;
      end
      ST_POP_PC: begin
        mem_valid = 1'b1; mem_addr = sp_q + WORD;
      end
      default: ;
    endcase
  end

  // Next-state and datapath update.
  always_comb begin
    st_d  = st_q;
    sp_d  = sp_q;
    pc_d  = pc_q;
    fmt_d = fmt_q;
    sr_d  = sr_q;
    va_d  = va_q;
    case (st_q)
      ST_IDLE: begin
        case (kind)
          RQ_RTE: begin
            sp_d = cur_sp;
            st_d = ST_POP_FMT;
          end
          RQ_SW, RQ_HW: begin
            sp_d  = sp_base - WORD;
            pc_d  = ret_w;
            fmt_d = fmt_w;
            sr_d  = entry_sr;
            va_d  = vec_addr;
            st_d  = ST_PUSH_PC;
          end
          default: ;
        endcase
      end
      ST_PUSH_PC: if (xfer) begin
        sp_d = sp_q - WORD;
        st_d = ST_PUSH_FMT;
      end
      ST_PUSH_FMT: if (xfer) st_d = ST_FETCH_VEC;
      ST_FETCH_VEC: if (xfer) begin
        pc_d = mem_rdata;
        st_d = ST_DONE;
      end
      ST_POP_FMT: if (xfer) begin
        fmt_d = mem_rdata;
        st_d  = ST_POP_PC;
      end
      ST_POP_PC: if (xfer) begin
        pc_d = mem_rdata;
        sp_d = (sp_q | {{(XLEN-2){1'b0}}, fmt_q[FMT_SPLO +: 2]}) + FRAME;
        sr_d = fmt_q[SR_W-1:0];
        st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sp_q  <= '0;
      pc_q  <= '0;
      fmt_q <= '0;
      sr_q  <= '0;
      va_q  <= '0;
    end else begin
      st_q  <= st_d;
      sp_q  <= sp_d;
      pc_q  <= pc_d;
      fmt_q <= fmt_d;
      sr_q  <= sr_d;
      va_q  <= va_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_DONE);
  assign new_pc = pc_q;
  assign new_sp = sp_q;
  assign new_sr = sr_q;

endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter int XLEN  = 32,
  parameter int NUM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_req,
  input logic             rte_req,
  input logic [2:0]       irq_level,
  input logic [15:0]      cur_sr,
  input logic             busy,
  input logic             done,
  input logic             mem_valid,
  input logic             mem_we,
  input logic [XLEN-1:0]  mem_addr,
  input logic [XLEN-1:0]  mem_wdata,
  input logic             mem_ready
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (sw_req || rte_req)) |=> busy);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sw_req && !rte_req && (irq_level <= cur_sr[10:8])) |=> !busy);

  p_push_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr[1:0] == 2'b00));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_valid_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (busy && !done));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind exc_frame_seq exc_frame_seq_chk #(.XLEN(XLEN), .NUM_W(NUM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .rte_req(rte_req),
  .irq_level(irq_level), .cur_sr(cur_sr), .busy(busy), .done(done),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/exc_frame_seq_tb.sv
`timescale 1ns/1ps
module exc_frame_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        sw_req, rte_req;
  logic [7:0]  sw_num, irq_vec;
  logic [2:0]  irq_level;
  logic [31:0] cur_pc, cur_sp, vbr;
  logic [15:0] cur_sr;
  logic [4:0]  cur_ccr;
  logic        busy, done;
  logic [31:0] new_pc, new_sp;
  logic [15:0] new_sr;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  exc_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_num(sw_num),
    .irq_level(irq_level), .irq_vec(irq_vec), .rte_req(rte_req),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_ccr(cur_ccr), .cur_sp(cur_sp),
    .vbr(vbr), .busy(busy), .done(done), .new_pc(new_pc), .new_sp(new_sp),
    .new_sr(new_sr), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bench memory: 1024 words; unwritten words read a computed pattern.
  logic [31:0] mem_arr [0:1023];
  logic        wv      [0:1023];
  logic        pl_en;
  logic [31:0] pl_addr, pl_data;

  function automatic logic [31:0] pattern(int i);
    return 32'h1000_0000 + i * 32'h0001_0003;
  endfunction

  function automatic logic [31:0] rd_word(logic [31:0] a);
    return wv[a[11:2]] ? mem_arr[a[11:2]] : pattern(int'(a[11:2]));
  endfunction

  assign mem_rdata = rd_word(mem_addr);

  logic [31:0] lg_a [0:63];
  logic [31:0] lg_d [0:63];
  logic        lg_w [0:63];
  int unsigned lg_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) wv[i] <= 1'b0;
      lg_n <= 0;
    end else begin
      if (pl_en) begin
        mem_arr[pl_addr[11:2]] <= pl_data;
        wv[pl_addr[11:2]] <= 1'b1;
      end
      if (mem_valid && mem_ready) begin
        lg_a[lg_n[5:0]] <= mem_addr;
        lg_w[lg_n[5:0]] <= mem_we;
        lg_d[lg_n[5:0]] <= mem_we ? mem_wdata : mem_rdata;
        lg_n <= lg_n + 1;
        if (mem_we) begin
          mem_arr[mem_addr[11:2]] <= mem_wdata;
          wv[mem_addr[11:2]] <= 1'b1;
        end
      end
    end
  end

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fmt(logic [7:0] num, logic [15:0] sr,
                                          logic [4:0] ccr, logic [31:0] sp);
    return 32'h4000_0000 | ({22'd0, num, 2'b00} << 16) | {30'd0, sp[1:0]} << 28
           | {16'd0, sr | {11'd0, ccr}};
  endfunction

  function automatic logic [15:0] exp_sr(bit hw, logic [2:0] lvl, logic [15:0] sr);
    logic [15:0] s;
    s = sr | 16'h2000;
    if (hw) s = (s & ~16'h1700) | ({13'd0, lvl} << 8);
    return s;
  endfunction

  task automatic preload(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic wait_done();
    int g;
    g = 0;
    while (!done && g < 500) begin
      @(negedge clk);
      g++;
    end
  endtask

  logic [31:0] last_fmt, last_ret;

  task automatic do_entry(input bit hw, input logic [7:0] num, input logic [2:0] lvl,
                          input logic [31:0] pc, input logic [15:0] sr,
                          input logic [4:0] ccr, input logic [31:0] sp,
                          input logic [31:0] vb);
    int unsigned b;
    logic [31:0] base, ret, fmt, va, hpc;
    bit trap;
    @(negedge clk);
    b = lg_n;
    cur_pc = pc; cur_sr = sr; cur_ccr = ccr; cur_sp = sp; vbr = vb;
    if (hw) begin irq_level = lvl; irq_vec = num; end
    else begin sw_req = 1'b1; sw_num = num; end
    @(negedge clk);
    sw_req = 1'b0; irq_level = 3'd0;
    chk(busy === 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
    wait_done();
    trap = !hw && num >= 8'd32 && num <= 8'd47;
    base = {sp[31:2], 2'b00};
    ret  = pc + (trap ? 32'd2 : 32'd0);
    fmt  = exp_fmt(num, sr, ccr, sp);
    va   = vb + {22'd0, num, 2'b00};
    hpc  = rd_word(va);
    last_fmt = fmt; last_ret = ret;
    chk(done === 1'b1, "R11 done seen", {31'd0, done}, 32'd1);
    chk(lg_n - b == 3, "R10 access count", lg_n - b, 32'd3);
    chk(lg_w[b[5:0]] && lg_a[b[5:0]] == base - 4, "R5 first push addr",
        lg_a[b[5:0]], base - 4);
    chk(lg_d[b[5:0]] == ret, "R6 return address", lg_d[b[5:0]], ret);
    chk(lg_w[(b+1)%64] && lg_a[(b+1)%64] == base - 8, "R5 second push addr",
        lg_a[(b+1)%64], base - 8);
    chk(lg_d[(b+1)%64] == fmt, "R4 format word", lg_d[(b+1)%64], fmt);
    chk(!lg_w[(b+2)%64] && lg_a[(b+2)%64] == va, "R7 vector read addr",
        lg_a[(b+2)%64], va);
    chk(new_pc == hpc, "R7 handler pc", new_pc, hpc);
    chk(new_sp == base - 8, "R5 new sp", new_sp, base - 8);
    chk(new_sr == exp_sr(hw, lvl, sr), "R8 new sr", {16'd0, new_sr},
        {16'd0, exp_sr(hw, lvl, sr)});
    @(negedge clk);
    chk(!busy && !done, "R11 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  task automatic do_rte(input logic [31:0] sp, input bit also_sw,
                        input logic [31:0] exp_sp, input logic [31:0] exp_pc,
                        input logic [15:0] exp_s);
    int unsigned b;
    @(negedge clk);
    b = lg_n;
    cur_sp = sp; rte_req = 1'b1;
    if (also_sw) begin sw_req = 1'b1; sw_num = 8'd5; irq_level = 3'd7; irq_vec = 8'd9; end
    @(negedge clk);
    rte_req = 1'b0; sw_req = 1'b0; irq_level = 3'd0;
    wait_done();
    chk(lg_n - b == 2, "R9 rte access count", lg_n - b, 32'd2);
    chk(!lg_w[b[5:0]] && lg_a[b[5:0]] == sp, "R9 format read addr",
        lg_a[b[5:0]], sp);
    chk(!lg_w[(b+1)%64] && lg_a[(b+1)%64] == sp + 4, "R9 pc read addr",
        lg_a[(b+1)%64], sp + 4);
    chk(new_pc == exp_pc, "R9 restored pc", new_pc, exp_pc);
    chk(new_sp == exp_sp, "R9 restored sp", new_sp, exp_sp);
    chk(new_sr == exp_s, "R9 restored sr", {16'd0, new_sr}, {16'd0, exp_s});
    if (also_sw) chk(lg_n - b == 2, "R2 rte wins priority", lg_n - b, 32'd2);
    @(negedge clk);
  endtask

  task automatic no_take(input logic [2:0] lvl, input logic [15:0] sr);
    @(negedge clk);
    cur_sr = sr; irq_level = lvl; irq_vec = 8'd30;
    @(negedge clk);
    chk(!busy, "R3 masked irq ignored", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(!busy && !mem_valid, "R3 still idle", {30'd0, busy, mem_valid}, 32'd0);
    irq_level = 3'd0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; pl_en = 1'b0; pl_addr = '0; pl_data = '0;
    sw_req = 1'b0; rte_req = 1'b0; sw_num = '0; irq_vec = '0; irq_level = '0;
    cur_pc = '0; cur_sr = '0; cur_ccr = '0; cur_sp = 32'hE00; vbr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid, "R1 reset state",
        {29'd0, busy, done, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_valid, "R1 after release",
        {29'd0, busy, done, mem_valid}, 32'd0);

    // Trap range boundaries (R6)
    do_entry(1'b0, 8'd31, 3'd0, 32'h100, 16'h0000, 5'h03, 32'hE00, 32'h0);
    do_entry(1'b0, 8'd32, 3'd0, 32'h200, 16'h0700, 5'h1F, 32'hE00, 32'h0);
    do_entry(1'b0, 8'd47, 3'd0, 32'h300, 16'h1000, 5'h00, 32'hE00, 32'h400);
    do_entry(1'b0, 8'd48, 3'd0, 32'h400, 16'h2000, 5'h10, 32'hE00, 32'h400);

    // Every low-bit pattern of the stack pointer, then round trip (R4, R9)
    for (int k = 0; k < 4; k++) begin
      logic [31:0] s;
      s = 32'hD10 + k;
      do_entry(1'b0, 8'd4 + k[7:0], 3'd0, 32'h800 + k, 16'h0300, 5'h05, s, 32'h0);
      do_rte(new_sp, 1'b0, s, last_ret, last_fmt[15:0]);
    end

    // Hardware interrupts: accepted and masked (R3, R8)
    do_entry(1'b1, 8'd64, 3'd7, 32'h900, 16'h1600, 5'h01, 32'hF00, 32'h0);
    do_entry(1'b1, 8'd25, 3'd3, 32'h904, 16'h3200, 5'h02, 32'hF02, 32'h0);
    no_take(3'd3, 16'h0300);
    no_take(3'd7, 16'h0700);
    no_take(3'd0, 16'h0000);

    // Priority: return wins over software and hardware requests (R2)
    preload(32'hA00, 32'h2000_1234);
    preload(32'hA04, 32'h0000_5678);
    do_rte(32'hA00, 1'b1, 32'hA0A, 32'h0000_5678, 16'h1234);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      bit hw;
      logic [2:0] lvl, msk;
      logic [15:0] sr;
      hw  = ($urandom % 2) == 1;
      lvl = 3'(1 + ($urandom % 7));
      msk = hw ? 3'($urandom % lvl) : 3'($urandom % 8);
      sr  = (16'($urandom) & 16'hF8FF) | ({13'd0, msk} << 8);
      do_entry(hw, 8'($urandom), lvl, $urandom & 32'hFFFF_FFFE, sr,
               5'($urandom), 32'hC00 + ($urandom % 32'h3F0),
               (($urandom % 2) == 1) ? 32'h400 : 32'h0);
    end

    finish_run();
  end

endmodule